// File: doc/BRIEF.md
# Asynchronous Page-Mode Flash Read Sequencer

This block is the read engine of a memory controller facing a 16-bit NOR-style flash that supports asynchronous page reads. A single request fetches four consecutive 16-bit words while the chip select stays asserted. The sequencer drives the flash-side strobes: one of eight chip selects, output enable, address valid, the word address, both byte enables and a bus-direction flag. It captures the data bus on edges of its own functional clock. No external clock is driven in this mode.

Two programmable counts set the timing, both in functional-clock cycles. An initial access count sets when the first word is captured, measured from the start of the read. A page interval count sets the spacing between each later capture and the one before it. The interval also sets how long each later address phase lasts, because the low word-address bits step at every capture. A selected wait source may stall the counting. Each captured word comes back on a response port with a one-cycle valid strobe and its position in the page. A done pulse closes the read.

Top module: `pfr_seq`

## Requirements
- R1: After reset all eight chip selects, output enable and address valid are high (inactive), both byte enables are high, the direction flag is 0 (controller driving), and busy, valid and done are 0.
- R2: A request is taken on a clock edge where `req_i` is high and the sequencer is idle. From that edge, `busy_o` is high, exactly one chip select goes low (bit index = `req_region_i`), and output enable goes low. A request seen while busy has no effect.
- R3: The first word is captured on the edge that lies A cycles after the accepting edge, where A = `access_time_i`. `rd_valid_o` is high in the cycle after that edge, and `rd_data_o` holds the bus value present at that edge.
- R4: Each later word is captured P cycles after the previous capture, where P = `page_time_i`.
- R5: Each read returns exactly four words with `rd_idx_o` equal to 0, 1, 2, 3 in that order. `rd_valid_o` is high for a single cycle per word.
- R6: `fl_addr_o` is {`req_page_i`, two-bit word index}. The index starts at 0 and steps by one on the same edge as each of the first three captures.
- R7: Address valid is low from the accepting edge up to the first capture edge, and is high at all other times.
- R8: On the edge one cycle after the fourth capture, chip select and output enable go high and `done_o` pulses for one cycle.
- R9: `fl_dir_in_o` is 1 exactly while output enable is low, and 0 otherwise.
- R10: Both byte enables are low while a chip select is low, and high otherwise.
- R11: A timing field of zero behaves as a count of one.
- R12: While `fl_wait_i[wait_sel_i]` (the bit selected at acceptance) is high on an edge, the pending count does not advance, so the capture moves one cycle later for each such edge. The other wait bits have no effect.
- R13: The page number, region, wait selection and both timing fields are sampled on the accepting edge. Changes to them during the read have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a page read |
| req_page_i | input | ADDR_W-2 | Page number (word address without its low two bits) |
| req_region_i | input | 3 | Chip-select region to target |
| wait_sel_i | input | 2 | Which wait source may stall the read |
| access_time_i | input | CNT_W | Cycles from read start to first capture |
| page_time_i | input | CNT_W | Cycles between successive captures |
| busy_o | output | 1 | A read is in progress |
| rd_valid_o | output | 1 | Captured word valid strobe |
| rd_idx_o | output | 2 | Position of the word in the page |
| rd_data_o | output | 16 | Captured word |
| done_o | output | 1 | Read complete pulse |
| fl_cs_n_o | output | 8 | Active-low chip selects |
| fl_oe_n_o | output | 1 | Active-low output enable |
| fl_adv_n_o | output | 1 | Active-low address valid |
| fl_be_n_o | output | 2 | Active-low byte enables |
| fl_dir_in_o | output | 1 | 1 while the flash drives the data bus |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_data_i | input | 16 | Flash data bus |
| fl_wait_i | input | 4 | Wait sources |

## Verification
The bench builds the block with ADDR_W = 12 and CNT_W = 4. A field of all ones is therefore only 15 cycles, so the longest initial access and page interval fit in a short run next to the zero-field case. The narrow address makes an all-ones page number cheap to cover, which shows that the top bits never change across the page. The flash data bus is modelled as a function of the address, so a word captured one cycle early or late shows up as wrong data as well as wrong timing.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    localparam int BUS_W      = 16;
    localparam int BE_W       = BUS_W / 8;
    localparam int PAGE_WORDS = 4;
    localparam int IDX_W      = $clog2(PAGE_WORDS);
    localparam int REGIONS    = 8;
    localparam int REG_W      = $clog2(REGIONS);
    localparam int WAIT_SRCS  = 4;
    localparam int WSEL_W     = $clog2(WAIT_SRCS);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CLOSE = 2'd2
    } seq_state_e;

    // What the flash pins must show in the next cycle
    typedef struct packed {
        logic             active;
        logic             adv;
        logic [REG_W-1:0] region;
    } pin_plan_t;

    // One captured word toward the requester
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [BUS_W-1:0] data;
    } word_beat_t;

endpackage

// File: rtl/pfr_timer.sv
module pfr_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             stall,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;

    // The capture edge is the one on which the count reaches one unstalled
    assign fire = run && !stall && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !stall && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R12: a stalled edge leaves the pending count untouched
    a_r12_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (run && stall && !load) |=> $stable(cnt_q));

    // R11: a running count is never zero, so a capture always arrives
    a_r11_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q != '0));

endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
    import pfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_i,
    input  logic [ADDR_W-IDX_W-1:0] req_page_i,
    input  logic [REG_W-1:0]        req_region_i,
    input  logic [WSEL_W-1:0]       wait_sel_i,
    input  logic [CNT_W-1:0]        access_time_i,
    input  logic [CNT_W-1:0]        page_time_i,
    input  logic [WAIT_SRCS-1:0]    wait_i,
    input  logic [BUS_W-1:0]        bus_i,
    input  logic                    fire_i,
    output logic                    tmr_run_o,
    output logic                    tmr_stall_o,
    output logic                    tmr_load_o,
    output logic [CNT_W-1:0]        tmr_val_o,
    output pin_plan_t               plan_o,
    output logic [ADDR_W-1:0]       addr_plan_o,
    output word_beat_t              beat_o,
    output logic                    done_o,
    output logic                    busy_o
);

    localparam int HI_W = ADDR_W - IDX_W;

    seq_state_e          state_q, state_d;
    logic [IDX_W-1:0]    idx_q, idx_d;
    logic [HI_W-1:0]     page_q, page_d;
    logic [REG_W-1:0]    region_q, region_d;
    logic [WSEL_W-1:0]   sel_q;
    logic [CNT_W-1:0]    ptime_q;
    logic                adv_q, adv_d;
    logic                accept, last_word;
    logic [CNT_W-1:0]    acc_eff, page_eff;
    word_beat_t          beat_q;
    logic                done_q;

    assign accept    = (state_q == ST_IDLE) && req_i;
    assign last_word = (idx_q == LAST_IDX);

    // Zero fields are raised to one cycle when they are latched
    assign acc_eff  = (access_time_i == '0) ? CNT_W'(1) : access_time_i;
    assign page_eff = (page_time_i   == '0) ? CNT_W'(1) : page_time_i;

    assign tmr_run_o   = (state_q == ST_FETCH);
    assign tmr_stall_o = (state_q == ST_FETCH) && wait_i[sel_q];
    assign tmr_load_o  = accept || (fire_i && !last_word);
    assign tmr_val_o   = accept ? acc_eff : ptime_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept)              state_d = ST_FETCH;
            ST_FETCH: if (fire_i && last_word) state_d = ST_CLOSE;
            ST_CLOSE:                          state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idx_d    = idx_q;
        page_d   = page_q;
        region_d = region_q;
        adv_d    = adv_q;
        if (accept) begin
            idx_d    = '0;
            page_d   = req_page_i;
            region_d = req_region_i;
            adv_d    = 1'b1;
        end else if (fire_i) begin
            adv_d = 1'b0;
            if (!last_word) begin
                idx_d = idx_q + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            page_q   <= '0;
            region_q <= '0;
            sel_q    <= '0;
            ptime_q  <= CNT_W'(1);
            adv_q    <= 1'b0;
            beat_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            page_q   <= page_d;
            region_q <= region_d;
            adv_q    <= adv_d;
            if (accept) begin
                sel_q   <= wait_sel_i;
                ptime_q <= page_eff;
            end
            beat_q.valid <= fire_i;
            if (fire_i) begin
                beat_q.idx  <= idx_q;
                beat_q.data <= bus_i;
            end
            done_q <= (state_q == ST_CLOSE);
        end
    end

    assign plan_o.active = (state_d != ST_IDLE);
    assign plan_o.adv    = adv_d;
    assign plan_o.region = region_d;
    assign addr_plan_o   = {page_d, idx_d};
    assign beat_o        = beat_q;
    assign done_o        = done_q;
    assign busy_o        = (state_q != ST_IDLE);

    // R13: the latched request stays fixed while words are being fetched
    a_r13_request_latched: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> ($stable(page_q) && $stable(region_q)
                                  && $stable(sel_q) && $stable(ptime_q)));

    // R5: the word index never moves past the last word of the page
    a_r5_index_bounded: assert property (@(posedge clk) disable iff (rst)
        (fire_i && last_word) |=> (state_q == ST_CLOSE));

endmodule

// File: rtl/pfr_pins.sv
module pfr_pins
    import pfr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_plan_t         plan_i,
    input  logic [ADDR_W-1:0] addr_plan_i,
    output logic [REGIONS-1:0] cs_n_o,
    output logic              oe_n_o,
    output logic              adv_n_o,
    output logic [BE_W-1:0]   be_n_o,
    output logic              dir_in_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [REGIONS-1:0] cs_n_q;
    logic [BE_W-1:0]    be_n_q;

    // One registered select per region, all driven from the same plan
    for (genvar g = 0; g < REGIONS; g++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst) begin
                cs_n_q[g] <= 1'b1;
            end else begin
                cs_n_q[g] <= !(plan_i.active && (plan_i.region == REG_W'(g)));
            end
        end
    end

    for (genvar b = 0; b < BE_W; b++) begin : g_be
        always_ff @(posedge clk) begin
            if (rst) begin
                be_n_q[b] <= 1'b1;
            end else begin
                be_n_q[b] <= !plan_i.active;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_n_o   <= 1'b1;
            adv_n_o  <= 1'b1;
            dir_in_o <= 1'b0;
            addr_o   <= '0;
        end else begin
            oe_n_o   <= !plan_i.active;
            adv_n_o  <= !(plan_i.active && plan_i.adv);
            dir_in_o <= plan_i.active;
            addr_o   <= addr_plan_i;
        end
    end

    assign cs_n_o = cs_n_q;
    assign be_n_o = be_n_q;

endmodule

// File: rtl/pfr_seq.sv
module pfr_seq
    import pfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_i,
    input  logic [ADDR_W-IDX_W-1:0] req_page_i,
    input  logic [REG_W-1:0]        req_region_i,
    input  logic [WSEL_W-1:0]       wait_sel_i,
    input  logic [CNT_W-1:0]        access_time_i,
    input  logic [CNT_W-1:0]        page_time_i,
    output logic                    busy_o,
    output logic                    rd_valid_o,
    output logic [IDX_W-1:0]        rd_idx_o,
    output logic [BUS_W-1:0]        rd_data_o,
    output logic                    done_o,
    output logic [REGIONS-1:0]      fl_cs_n_o,
    output logic                    fl_oe_n_o,
    output logic                    fl_adv_n_o,
    output logic [BE_W-1:0]         fl_be_n_o,
    output logic                    fl_dir_in_o,
    output logic [ADDR_W-1:0]       fl_addr_o,
    input  logic [BUS_W-1:0]        fl_data_i,
    input  logic [WAIT_SRCS-1:0]    fl_wait_i
);

    logic              tmr_run, tmr_stall, tmr_load, fire;
    logic [CNT_W-1:0]  tmr_val;
    pin_plan_t         plan;
    logic [ADDR_W-1:0] addr_plan;
    word_beat_t        beat;

    pfr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (tmr_run),
        .stall    (tmr_stall),
        .load     (tmr_load),
        .load_val (tmr_val),
        .fire     (fire)
    );

    pfr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req_i),
        .req_page_i    (req_page_i),
        .req_region_i  (req_region_i),
        .wait_sel_i    (wait_sel_i),
        .access_time_i (access_time_i),
        .page_time_i   (page_time_i),
        .wait_i        (fl_wait_i),
        .bus_i         (fl_data_i),
        .fire_i        (fire),
        .tmr_run_o     (tmr_run),
        .tmr_stall_o   (tmr_stall),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .plan_o        (plan),
        .addr_plan_o   (addr_plan),
        .beat_o        (beat),
        .done_o        (done_o),
        .busy_o        (busy_o)
    );

    pfr_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .plan_i      (plan),
        .addr_plan_i (addr_plan),
        .cs_n_o      (fl_cs_n_o),
        .oe_n_o      (fl_oe_n_o),
        .adv_n_o     (fl_adv_n_o),
        .be_n_o      (fl_be_n_o),
        .dir_in_o    (fl_dir_in_o),
        .addr_o      (fl_addr_o)
    );

    assign rd_valid_o = beat.valid;
    assign rd_idx_o   = beat.idx;
    assign rd_data_o  = beat.data;

    // R2: never more than one region selected
    a_r2_single_region: assert property (@(posedge clk) disable iff (rst)
        $countones(~fl_cs_n_o) <= 1);

    // R8: the page closes on the edge after the fourth word
    a_r8_close_after_last: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && rd_idx_o == LAST_IDX) |=> (done_o && fl_oe_n_o && (&fl_cs_n_o)));

    // R9: direction follows output enable
    a_r9_dir_with_oe: assert property (@(posedge clk) disable iff (rst)
        fl_dir_in_o == !fl_oe_n_o);

    // R10: byte enables track the chip select
    a_r10_be_with_cs: assert property (@(posedge clk) disable iff (rst)
        (&fl_cs_n_o) == (&fl_be_n_o));

    // R7: address valid only during the first address phase
    a_r7_adv_first_phase: assert property (@(posedge clk) disable iff (rst)
        !fl_adv_n_o |-> (fl_addr_o[IDX_W-1:0] == '0 && !fl_oe_n_o));

    // R6: after an early word the address already points at the next one
    a_r6_addr_next: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && rd_idx_o != LAST_IDX) |-> (fl_addr_o[IDX_W-1:0] == rd_idx_o + IDX_W'(1)));

endmodule

// File: tb/test_pfr_seq.sv
module test_pfr_seq;
    import pfr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int CW = 4;
    localparam int PW = AW - 2;
    localparam int WATCHDOG = 20000;
    localparam logic [15:0] SEED = 16'hC3A5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req = 1'b0;
    logic [PW-1:0]  page = '0;
    logic [2:0]     region = '0;
    logic [1:0]     wsel = '0;
    logic [CW-1:0]  acc = '0;
    logic [CW-1:0]  pgt = '0;
    logic [3:0]     wait_v = '0;
    logic           busy, valid, done, oe_n, adv_n, dir_in;
    logic [1:0]     idx, be_n;
    logic [15:0]    rdata, fdata;
    logic [7:0]     cs_n;
    logic [AW-1:0]  faddr;

    assign fdata = SEED ^ 16'(faddr);

    pfr_seq #(.ADDR_W(AW), .CNT_W(CW)) i_pfr_seq (
        .clk(clk), .rst(rst), .req_i(req), .req_page_i(page),
        .req_region_i(region), .wait_sel_i(wsel),
        .access_time_i(acc), .page_time_i(pgt),
        .busy_o(busy), .rd_valid_o(valid), .rd_idx_o(idx), .rd_data_o(rdata),
        .done_o(done), .fl_cs_n_o(cs_n), .fl_oe_n_o(oe_n), .fl_adv_n_o(adv_n),
        .fl_be_n_o(be_n), .fl_dir_in_o(dir_in), .fl_addr_o(faddr),
        .fl_data_i(fdata), .fl_wait_i(wait_v)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int          ph, mcnt, midx, mpage_t, mregion, msel, mvidx;
    logic [AW-1:0] maddr;
    bit          madv, mvalid, mdone;
    logic [15:0] mdata;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            ph = 0; mcnt = 0; midx = 0; mpage_t = 1; mregion = 0; msel = 0;
            maddr = '0; madv = 0; mvalid = 0; mdone = 0; mdata = '0; mvidx = 0;
        end else begin
            mvalid = 0;
            mdone  = 0;
            case (ph)
                0: if (req) begin
                    ph = 1; mcnt = eff(int'(acc)); mpage_t = eff(int'(pgt));
                    midx = 0; maddr = {page, 2'b00}; mregion = int'(region);
                    msel = int'(wsel); madv = 1;
                end
                1: if (!wait_v[msel]) begin
                    if (mcnt == 1) begin
                        mvalid = 1; mdata = SEED ^ 16'(maddr); mvidx = midx; madv = 0;
                        if (midx == 3) ph = 2;
                        else begin
                            midx++; maddr[1:0] = 2'(midx); mcnt = mpage_t;
                        end
                    end else mcnt--;
                end
                default: begin ph = 0; mdone = 1; end
            endcase
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && cyc > 0) begin
            logic [7:0] ecs;
            ecs = (ph != 0) ? ~(8'd1 << mregion) : 8'hFF;
            chk(cs_n == ecs, "R2", "chip selects", int'(cs_n), int'(ecs));
            chk(oe_n == (ph == 0), "R8", "output enable", int'(oe_n), int'(ph == 0));
            chk(busy == (ph != 0), "R2", "busy", int'(busy), int'(ph != 0));
            chk(adv_n == !madv, "R7", "address valid", int'(adv_n), int'(!madv));
            chk(faddr == maddr, "R6", "address", int'(faddr), int'(maddr));
            chk(be_n == ((ph != 0) ? 2'b00 : 2'b11), "R10", "byte enables",
                int'(be_n), (ph != 0) ? 0 : 3);
            chk(dir_in == (ph != 0), "R9", "direction", int'(dir_in), int'(ph != 0));
            chk(valid == mvalid, "R5", "valid strobe", int'(valid), int'(mvalid));
            chk(done == mdone, "R8", "done pulse", int'(done), int'(mdone));
            if (mvalid) begin
                chk(idx == 2'(mvidx), "R5", "word index", int'(idx), mvidx);
                chk(rdata == mdata, "R3", "captured word", int'(rdata), int'(mdata));
            end
        end
        if (cyc > WATCHDOG) begin
            chk(1'b0, "watchdog", "run length", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_read(input logic [PW-1:0] pg_num, input logic [2:0] reg_n,
                           input int a_f, input int p_f, input int sel,
                           input int stall_n, input bit churn, input string tag);
        int t0, k, done_at;
        int vq[$];
        done_at = -1;
        @(negedge clk);
        page = pg_num; region = reg_n; acc = CW'(a_f); pgt = CW'(p_f);
        wsel = 2'(sel); wait_v = ~(4'b0001 << sel); req = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        req = churn;
        if (churn) begin
            page = ~pg_num; region = reg_n + 3'd1; acc = CW'(1); pgt = CW'(1);
            wsel = 2'(sel + 1);
        end
        if (stall_n > 0) wait_v[sel] = 1'b1;
        k = 0;
        while (done_at < 0) begin
            @(negedge clk);
            k++;
            if (k == 1) req = 1'b0;
            if (k >= stall_n) wait_v[sel] = 1'b0;
            if (valid) vq.push_back(cyc);
            if (done) done_at = cyc;
        end
        wait_v = '0;
        chk(vq.size() == 4, "R5", "words per read", vq.size(), 4);
        if (vq.size() == 4) begin
            chk(vq[0] - t0 == eff(a_f) + stall_n, tag, "first capture delay",
                vq[0] - t0, eff(a_f) + stall_n);
            for (int i = 1; i < 4; i++)
                chk(vq[i] - vq[i-1] == eff(p_f), "R4", "capture interval",
                    vq[i] - vq[i-1], eff(p_f));
            chk(done_at == vq[3] + 1, "R8", "done after last word", done_at, vq[3] + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen while reset is still applied
        chk(cs_n == 8'hFF, "R1", "chip selects at reset", int'(cs_n), 'hFF);
        chk(oe_n && adv_n, "R1", "strobes at reset", int'({oe_n, adv_n}), 3);
        chk(be_n == 2'b11, "R1", "byte enables at reset", int'(be_n), 3);
        chk(!dir_in && !busy && !valid && !done, "R1", "flags at reset",
            int'({dir_in, busy, valid, done}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        do_read(10'h169, 3'd3, 5, 2, 0, 0, 1'b0, "R3");
        do_read(10'h000, 3'd0, 0, 0, 1, 0, 1'b0, "R11");     // zero fields count as one
        do_read(10'h3FF, 3'd7, 15, 15, 2, 0, 1'b0, "R3");    // widest fields, top page
        do_read(10'h0A5, 3'd1, 8, 3, 1, 3, 1'b0, "R12");     // selected wait held 3 edges
        do_read(10'h2C3, 3'd5, 4, 1, 3, 0, 1'b1, "R13");     // inputs churn mid-read
        do_read(10'h155, 3'd6, 1, 7, 2, 0, 1'b0, "R12");     // other wait bits high
        do_read(10'h001, 3'd2, 2, 0, 0, 1, 1'b1, "R12");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule